// File: doc/BRIEF.md
# Floating-Point Conditional Branch Evaluator

This block decides the outcome of a floating-point conditional branch. Each cycle it can take one instruction word, the address of that instruction, and the two-bit result of the most recent floating-point compare. When the word is a floating-point branch, the block picks one of sixteen conditions. Each condition is a set of the four compare outcomes: equal, less, greater and unordered. The block reports whether the branch is taken and computes the word-aligned target.

It also tells the fetch logic what happens to the delay slot. The slot can run or be squashed, and control can then continue sequentially or move to the target. The annul bit acts differently for an untaken branch and for the unconditional branch. A running count of taken branches is kept for performance monitoring.

All results are registered and appear one clock after the inputs are sampled.

Top module: `fpbr_eval`

## Requirements
- R1: A word counts as a branch only when `valid_i` is high, bits 31:30 are 00 and bits 24:22 are 110. Otherwise, on the next cycle `hit_o`, `taken_o` and `annul_o` are 0, `npc_sel_o` is 00 and the taken count does not change.
- R2: The condition code is in bits 28:25, and the compare code is read as 0 = equal, 1 = less, 2 = greater, 3 = unordered. Codes 0 to 7 are taken as follows: 0 never; 1 on less, greater or unordered; 2 on less or greater; 3 on less or unordered; 4 on less; 5 on greater or unordered; 6 on greater; 7 on unordered.
- R3: Codes 8 to 15 are taken as follows: 8 always; 9 on equal; 10 on equal or unordered; 11 on equal or greater; 12 on equal, greater or unordered; 13 on equal or less; 14 on equal, less or unordered; 15 on equal, less or greater.
- R4: `target_o` is the instruction address plus bits 21:0 sign-extended from bit 21 and shifted left by two, modulo 2^ADDR_W.
- R5: An untaken branch with the annul bit (bit 29) set gives `annul_o`=1 and `npc_sel_o`=01, meaning skip the delay slot and go on at address+8.
- R6: An untaken branch with the annul bit clear gives `annul_o`=0 and `npc_sel_o`=00, meaning run the delay slot and continue sequentially.
- R7: Code 8 with the annul bit set gives `taken_o`=1, `annul_o`=1 and `npc_sel_o`=11, meaning squash the delay slot and jump straight to the target.
- R8: Every other taken branch gives `annul_o`=0 and `npc_sel_o`=10, meaning run the delay slot, then the target. This includes conditional branches with the annul bit set.
- R9: Outputs are registered with a latency of one cycle. A synchronous reset clears every output, including the count.
- R10: `taken_cnt_o` rises by one, wrapping modulo 2^CNT_W, in the same cycle that `taken_o` is 1, and holds in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Address of the instruction |
| fcc_i | input | 2 | Floating-point compare result |
| hit_o | output | 1 | Last word was a recognised FP branch |
| taken_o | output | 1 | Branch taken |
| target_o | output | ADDR_W | Branch target address |
| npc_sel_o | output | 2 | 00 sequential, 01 skip slot, 10 slot then target, 11 direct to target |
| annul_o | output | 1 | Squash the delay-slot instruction |
| taken_cnt_o | output | CNT_W | Count of taken branches |

## Verification
Two things resolve in the same cycle: the taken-count increment and the delay-slot decision. The count also wraps, and a wrap can land on the unconditional annulled branch, the one case where taken and annul are both high. The bench builds the count four bits wide and sweeps every condition, compare code and annul value back to back, so the count wraps many times and does so on such branches. At each sample it checks the count, `taken_o`, `annul_o` and `npc_sel_o` together against a model computed from the requirements.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ     = 2'b00,
    NPC_SKIP    = 2'b01,
    NPC_DELAYED = 2'b10,
    NPC_DIRECT  = 2'b11
  } npc_sel_e;

  localparam logic [1:0] OP_FIELD_BR  = 2'b00;
  localparam logic [2:0] OP2_FIELD_FB = 3'b110;
  localparam logic [3:0] COND_ALWAYS  = 4'b1000;

  // Outcome set for codes 0..7; bit index = compare code (0 E, 1 L, 2 G, 3 U).
  // Codes 8..15 are the complements of these.
  function automatic logic [3:0] base_mask(input logic [2:0] c);
    case (c)
      3'd0:    base_mask = 4'b0000;
      3'd1:    base_mask = 4'b1110;
      3'd2:    base_mask = 4'b0110;
      3'd3:    base_mask = 4'b1010;
      3'd4:    base_mask = 4'b0010;
      3'd5:    base_mask = 4'b1100;
      3'd6:    base_mask = 4'b0100;
      default: base_mask = 4'b1000;
    endcase
  endfunction
endpackage

// File: rtl/fpbr_cond.sv
module fpbr_cond #(
  parameter int COND_W = 4,
  parameter int FCC_W  = 2
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [FCC_W-1:0]  fcc_i,
  output logic              take_o
);
  localparam int NCOND = 1 << COND_W;
  localparam int NOUT  = 1 << FCC_W;

  logic [NOUT-1:0] mask_tbl [NCOND];

  for (genvar g = 0; g < NCOND; g++) begin : g_mask
    localparam logic [COND_W-1:0] CODE = COND_W'(g);
    assign mask_tbl[g] = fpbr_pkg::base_mask(CODE[2:0]) ^ {NOUT{CODE[COND_W-1]}};
  end

  always_comb take_o = mask_tbl[cond_i][fcc_i];
endmodule

// File: rtl/fpbr_target.sv
module fpbr_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int PAD_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = {{PAD_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
    target_o = pc_i + offset;
  end
endmodule

// File: rtl/fpbr_ctrl.sv
module fpbr_ctrl (
  input  logic                 hit_i,
  input  logic                 take_i,
  input  logic                 annul_bit_i,
  input  logic                 always_i,
  output fpbr_pkg::npc_sel_e   sel_o,
  output logic                 annul_o
);
  import fpbr_pkg::*;

  always_comb begin
    sel_o   = NPC_SEQ;
    annul_o = 1'b0;
    if (hit_i) begin
      if (!take_i) begin
        annul_o = annul_bit_i;
        sel_o   = annul_bit_i ? NPC_SKIP : NPC_SEQ;
      end else if (always_i && annul_bit_i) begin
        annul_o = 1'b1;
        sel_o   = NPC_DIRECT;
      end else begin
        sel_o   = NPC_DELAYED;
      end
    end
  end
endmodule

// File: rtl/fpbr_eval.sv
module fpbr_eval #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [1:0]        fcc_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [1:0]        npc_sel_o,
  output logic              annul_o,
  output logic [CNT_W-1:0]  taken_cnt_o
);
  import fpbr_pkg::*;

  localparam int DISP_W = 22;
  localparam int COND_W = 4;

  logic              is_br;
  logic              cond_true;
  logic              take;
  logic              annul_nx;
  logic [ADDR_W-1:0] tgt_nx;
  npc_sel_e          sel_nx;
  logic [COND_W-1:0] cond_code;

  assign cond_code = instr_i[28:25];
  assign is_br     = valid_i && (instr_i[31:30] == OP_FIELD_BR)
                             && (instr_i[24:22] == OP2_FIELD_FB);
  assign take      = is_br && cond_true;

  fpbr_cond #(.COND_W(COND_W), .FCC_W(2)) u_cond (
    .cond_i (cond_code),
    .fcc_i  (fcc_i),
    .take_o (cond_true)
  );

  fpbr_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (instr_i[DISP_W-1:0]),
    .target_o (tgt_nx)
  );

  fpbr_ctrl u_ctrl (
    .hit_i       (is_br),
    .take_i      (take),
    .annul_bit_i (instr_i[29]),
    .always_i    (cond_code == COND_ALWAYS),
    .sel_o       (sel_nx),
    .annul_o     (annul_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o       <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
      npc_sel_o   <= NPC_SEQ;
      annul_o     <= 1'b0;
      taken_cnt_o <= '0;
    end else begin
      hit_o     <= is_br;
      taken_o   <= take;
      target_o  <= is_br ? tgt_nx : '0;
      npc_sel_o <= sel_nx;
      annul_o   <= annul_nx;
      if (take) taken_cnt_o <= taken_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/fpbr_eval_chk.sv
module fpbr_eval_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [31:0]       instr_i,
  input logic              hit_o,
  input logic              taken_o,
  input logic [1:0]        npc_sel_o,
  input logic              annul_o,
  input logic [CNT_W-1:0]  taken_cnt_o
);
  logic past_ok;
  logic br_in;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign br_in = valid_i && instr_i[31:30] == 2'b00 && instr_i[24:22] == 3'b110;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (!taken_o && !annul_o && npc_sel_o == 2'b00));

  a_r2_never_untaken: assert property (@(posedge clk) disable iff (rst)
    (past_ok && br_in && instr_i[28:25] == 4'd0) |=> (hit_o && !taken_o));

  a_r3_always_taken: assert property (@(posedge clk) disable iff (rst)
    (past_ok && br_in && instr_i[28:25] == 4'd8) |=> (hit_o && taken_o));

  a_r5_skip_sel: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !taken_o && annul_o) |-> npc_sel_o == 2'b01);

  a_r7_direct_sel: assert property (@(posedge clk) disable iff (rst)
    (taken_o && annul_o) |-> npc_sel_o == 2'b11);

  a_r8_delayed_sel: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !annul_o) |-> npc_sel_o == 2'b10);

  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    (past_ok && taken_o) |-> taken_cnt_o == $past(taken_cnt_o) + 1'b1);

  a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !taken_o) |-> $stable(taken_cnt_o));
endmodule

bind fpbr_eval fpbr_eval_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .valid_i     (valid_i),
  .instr_i     (instr_i),
  .hit_o       (hit_o),
  .taken_o     (taken_o),
  .npc_sel_o   (npc_sel_o),
  .annul_o     (annul_o),
  .taken_cnt_o (taken_cnt_o)
);

// File: tb/test_fpbr_eval.sv
module test_fpbr_eval;
  localparam int AW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [31:0]   instr_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [1:0]    fcc_i = '0;
  logic          hit_o, taken_o, annul_o;
  logic [AW-1:0] target_o;
  logic [1:0]    npc_sel_o;
  logic [CW-1:0] taken_cnt_o;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_cnt = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpbr_eval #(.ADDR_W(AW), .CNT_W(CW)) i_fpbr_eval (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .fcc_i(fcc_i), .hit_o(hit_o), .taken_o(taken_o), .target_o(target_o),
    .npc_sel_o(npc_sel_o), .annul_o(annul_o), .taken_cnt_o(taken_cnt_o)
  );

  // Compare codes: 0 E, 1 L, 2 G, 3 U
  function automatic bit model_take(input int c, input int f);
    bit e, l, g, u;
    e = (f == 0); l = (f == 1); g = (f == 2); u = (f == 3);
    case (c)
      0: return 0;             1: return l | g | u;
      2: return l | g;         3: return l | u;
      4: return l;             5: return g | u;
      6: return g;             7: return u;
      8: return 1;             9: return e;
      10: return e | u;        11: return e | g;
      12: return e | g | u;    13: return e | l;
      14: return e | l | u;    default: return e | l | g;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_br(input int c, input int f, input bit an,
                          input logic [21:0] disp, input logic [AW-1:0] pc);
    bit t;
    logic [AW-1:0] tgt;
    logic [1:0] sel;
    bit ann;
    instr_i = {2'b00, an, 4'(c), 3'b110, disp};
    pc_i    = pc;
    fcc_i   = 2'(f);
    valid_i = 1'b1;
    t   = model_take(c, f);
    tgt = pc + AW'({{(AW-24){disp[21]}}, disp, 2'b00});
    if (!t)                 begin sel = an ? 2'b01 : 2'b00; ann = an; end
    else if (c == 8 && an)  begin sel = 2'b11; ann = 1'b1; end
    else                    begin sel = 2'b10; ann = 1'b0; end
    if (t) exp_cnt = exp_cnt + 1'b1;
    @(negedge clk);
    chk("R1 hit", hit_o, 1);
    chk(c < 8 ? "R2 taken" : "R3 taken", taken_o, t);
    chk("R4 target", target_o, tgt);
    if (!t && an)      chk("R5 sel/annul", {npc_sel_o, annul_o}, {sel, ann});
    else if (!t)       chk("R6 sel/annul", {npc_sel_o, annul_o}, {sel, ann});
    else if (c == 8 && an) chk("R7 sel/annul", {npc_sel_o, annul_o}, {sel, ann});
    else               chk("R8 sel/annul", {npc_sel_o, annul_o}, {sel, ann});
    chk("R10 count", taken_cnt_o, exp_cnt);
  endtask

  task automatic apply_raw(input bit v, input logic [31:0] w, input string req);
    instr_i = w;
    valid_i = v;
    fcc_i   = 2'd0;
    @(negedge clk);
    chk({req, " hit"}, hit_o, 0);
    chk({req, " taken"}, taken_o, 0);
    chk({req, " sel/annul"}, {npc_sel_o, annul_o}, 0);
    chk("R1 count", taken_cnt_o, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset hit", hit_o, 0);
    chk("R9 reset taken", taken_o, 0);
    chk("R9 reset count", taken_cnt_o, 0);
    chk("R9 reset sel", npc_sel_o, 0);
    rst = 1'b0;
    // Full sweep: every condition, compare code and annul value
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        for (int an = 0; an < 2; an++)
          apply_br(c, f, an[0], 22'(c * 37 + f * 1021 + an * 200001),
                   AW'(32'h1000_0000 + c * 64 + f * 8 + an * 4));
    // Displacement extremes, incl. wrap of the address space
    apply_br(8, 0, 0, 22'h1FFFFF, 32'h0000_0100);
    apply_br(8, 1, 0, 22'h200000, 32'h0080_0000);
    apply_br(8, 2, 0, 22'h3FFFFF, 32'h0000_0000);
    apply_br(8, 3, 0, 22'h000001, 32'hFFFF_FFFC);
    // Non-branch words: ignored (R1)
    apply_raw(1'b0, {2'b00, 1'b1, 4'd8, 3'b110, 22'h5}, "R1 valid low");
    apply_raw(1'b1, {2'b01, 1'b1, 4'd8, 3'b110, 22'h5}, "R1 op field");
    apply_raw(1'b1, {2'b00, 1'b1, 4'd8, 3'b010, 22'h5}, "R1 op2 field");
    apply_raw(1'b1, {2'b10, 1'b0, 4'd8, 3'b111, 22'h5}, "R1 both fields");
    // Reset mid-run clears count (R9)
    valid_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    exp_cnt = '0;
    chk("R9 reset count again", taken_cnt_o, 0);
    rst = 1'b0;
    apply_br(9, 0, 1, 22'h10, 32'h200);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule